// File: doc/BRIEF.md
# Serial Register Access Port

This block lets an external host read and write a small file of 8-bit registers over a four-wire serial link. The link has a serial clock, an active-low select, a data input and a data output. The block runs entirely on the system clock `clk`. It samples the serial pins on that clock and finds the serial clock edges itself, so the serial clock has to be several times slower than `clk`. The host must hold each serial clock level for at least two system clock periods.

Each transaction begins when the select falls. The host then shifts in a 16-bit command word, least significant bit first, on rising serial clock edges. For a write, 8 data bits follow, also least significant bit first. The register is only updated after the last of them has arrived. For a read, the block fetches the addressed register when the command word is complete and shifts it out least significant bit first.

A static edge-select input chooses which serial clock edge launches each output bit. The output pad is modelled as a data bit plus an enable. The enable is raised only during the data phase of a read.

Top module: `sreg_port`

## Requirements
- R1: The bit on `sdi` is taken at each rising edge of `sclk` while selected, command bit 0 first. In the 16-bit command, bit 0 is the direction (1 = read, 0 = write) and bits 6..1 are the register address. Bits 15..7 have no effect.
- R2: In a write, the 8 bits after the command (bit 0 first) are stored in the addressed register only after the 24th rising `sclk` edge. A later read of that register returns the byte.
- R3: A read returns the addressed register, bit 0 first. With `edge_sel` = 1, bit 0 is on `sdo` from the 16th rising `sclk` edge, and each later bit is launched on the falling edge that follows rising edges 17 to 23, for sampling on the next rising edge. With `edge_sel` = 0, bit 0 is on `sdo` from the 16th rising edge, and bits 1 to 7 are launched on rising edges 17 to 23, for sampling on the falling edges.
- R4: While `cs_n` is high, `sdo_oe` is 0, and from the next clock `sdo` is 0.
- R5: `sdo_oe` stays 0 during the command phase of every transaction and during the whole of a write transaction.
- R6: If `cs_n` rises before the 24th rising `sclk` edge of a write, nothing is written. This includes the case where `cs_n` rises in the same clock as that edge.
- R7: A transaction starts only on a high-to-low change of `cs_n`. If `cs_n` is already low when reset is released, `sclk` activity is ignored until `cs_n` has been high.
- R8: Addresses at or above `NREGS` read as 0, and writes to them change no register.
- R9: Rising `sclk` edges after the 24th in a transaction are ignored. The register keeps the byte from bits 17 to 24.
- R10: After reset every register holds 0, `sdo_oe` is 0 and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state is updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sclk | input | 1 | Serial clock from the host, sampled on `clk` |
| cs_n | input | 1 | Active-low transaction select |
| sdi | input | 1 | Serial data from the host |
| edge_sel | input | 1 | 1: read bits launched on falling `sclk` edges; 0: launched on rising edges |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high-impedance |

## Verification
The interesting collisions are between the end of a transaction and `cs_n` deassertion. The bench raises `cs_n` in the same system clock as the 24th rising `sclk` edge of a write. Because the deselect wins, the register must keep its earlier value, and a later read confirms this. The second collision is the read-data capture against the output launch. On the 16th rising edge the register is fetched, and with `edge_sel` = 0 that same kind of edge is also the launch edge. The bench reads the same register under both edge settings and compares `sdo` with a behavioural model on every clock, so a bit lost or doubled at that boundary shows up.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int CMD_BITS   = 16;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = CMD_BITS + DATA_BITS;
  localparam int ADDR_W     = 6;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  localparam logic [CNT_W-1:0] CNT_CMD        = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] CNT_CMD_LAST   = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FRAME      = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_FRAME_LAST = CNT_W'(FRAME_BITS - 1);

  typedef struct packed {
    logic                 stb;
    logic [ADDR_W-1:0]    addr;
    logic [DATA_BITS-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/sreg_edge_det.sv
module sreg_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  always_comb begin
    sclk_rise = sclk & ~sclk_q;
    sclk_fall = ~sclk & sclk_q;
  end
endmodule

// File: rtl/sreg_rx.sv
module sreg_rx
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              sclk_rise,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              armed,
  output logic              cap_stb,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_rd,
  output logic              cmd_rd,
  output wr_req_t           wr_req
);
  logic [CMD_BITS-1:0]  cmd_q, cmd_d, cmd_shift;
  logic [DATA_BITS-1:0] dat_q, dat_d, dat_shift;
  logic [CNT_W-1:0]     cnt_d;
  logic                 armed_d;
  wr_req_t              wr_d;
  logic                 take;
  logic                 cmd_phase;

  always_comb begin
    take      = armed && !cs_n && sclk_rise && (bit_cnt < CNT_FRAME);
    cmd_phase = bit_cnt < CNT_CMD;
    cmd_shift = {sdi, cmd_q[CMD_BITS-1:1]};
    dat_shift = {sdi, dat_q[DATA_BITS-1:1]};
    cap_stb   = take && (bit_cnt == CNT_CMD_LAST);
    cap_addr  = cmd_shift[ADDR_W:1];
    cap_rd    = cmd_shift[0];
    cmd_rd    = cmd_q[0];
  end

  always_comb begin
    cnt_d   = bit_cnt;
    cmd_d   = cmd_q;
    dat_d   = dat_q;
    armed_d = armed;
    wr_d    = '{stb: 1'b0, addr: '0, data: '0};
    if (cs_n) begin
      armed_d = 1'b1;
      cnt_d   = '0;
      cmd_d   = '0;
      dat_d   = '0;
    end else if (take) begin
      cnt_d = bit_cnt + CNT_W'(1);
      if (cmd_phase) cmd_d = cmd_shift;
      else           dat_d = dat_shift;
      if ((bit_cnt == CNT_FRAME_LAST) && !cmd_q[0]) begin
        wr_d.stb  = 1'b1;
        wr_d.addr = cmd_q[ADDR_W:1];
        wr_d.data = dat_shift;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      cmd_q   <= '0;
      dat_q   <= '0;
      armed   <= 1'b0;
      wr_req  <= '{stb: 1'b0, addr: '0, data: '0};
    end else begin
      bit_cnt <= cnt_d;
      cmd_q   <= cmd_d;
      dat_q   <= dat_d;
      armed   <= armed_d;
      wr_req  <= wr_d;
    end
  end
endmodule

// File: rtl/sreg_tx.sv
module sreg_tx
  import sreg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 armed,
  input  logic                 edge_sel,
  input  logic                 sclk_rise,
  input  logic                 sclk_fall,
  input  logic [CNT_W-1:0]     bit_cnt,
  input  logic                 cap_stb,
  input  logic                 cap_rd,
  input  logic [DATA_BITS-1:0] cap_data,
  output logic                 sdo,
  output logic                 rd_active
);
  logic [DATA_BITS-1:0] osr_q, osr_d;
  logic                 act_d;
  logic                 shift_en;
  logic                 fall_slot, rise_slot;

  always_comb begin
    fall_slot = sclk_fall && (bit_cnt > CNT_CMD);
    rise_slot = sclk_rise && (bit_cnt >= CNT_CMD) && (bit_cnt < CNT_FRAME);
    shift_en  = rd_active && armed && !cs_n && (edge_sel ? fall_slot : rise_slot);
  end

  always_comb begin
    osr_d = osr_q;
    act_d = rd_active;
    if (cs_n) begin
      osr_d = '0;
      act_d = 1'b0;
    end else if (cap_stb && cap_rd) begin
      osr_d = cap_data;
      act_d = 1'b1;
    end else if (shift_en) begin
      osr_d = {1'b0, osr_q[DATA_BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osr_q     <= '0;
      rd_active <= 1'b0;
    end else begin
      osr_q     <= osr_d;
      rd_active <= act_d;
    end
  end

  assign sdo = osr_q[0];
endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile
  import sreg_pkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  wr_req_t              wr_req,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_BITS-1:0] rd_data
);
  logic [DATA_BITS-1:0] mem_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic wr_en;
    assign wr_en = wr_req.stb && (wr_req.addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem_q[g] <= '0;
      else if (wr_en) mem_q[g] <= wr_req.data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = mem_q[i];
    end
  end
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  input  logic edge_sel,
  output logic sdo,
  output logic sdo_oe
);
  logic                 rst_meta, rst_sync_n;
  logic                 sclk_rise, sclk_fall;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 armed;
  logic                 cap_stb, cap_rd, cmd_rd;
  logic [ADDR_W-1:0]    cap_addr;
  logic [DATA_BITS-1:0] rd_data;
  wr_req_t              wr_req;
  logic                 wr_stb;
  logic                 rd_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sreg_edge_det u_edge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  sreg_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_n      (cs_n),
    .sdi       (sdi),
    .sclk_rise (sclk_rise),
    .bit_cnt   (bit_cnt),
    .armed     (armed),
    .cap_stb   (cap_stb),
    .cap_addr  (cap_addr),
    .cap_rd    (cap_rd),
    .cmd_rd    (cmd_rd),
    .wr_req    (wr_req)
  );

  sreg_regfile #(.NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_req  (wr_req),
    .rd_addr (cap_addr),
    .rd_data (rd_data)
  );

  sreg_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_n      (cs_n),
    .armed     (armed),
    .edge_sel  (edge_sel),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .bit_cnt   (bit_cnt),
    .cap_stb   (cap_stb),
    .cap_rd    (cap_rd),
    .cap_data  (rd_data),
    .sdo       (sdo),
    .rd_active (rd_active)
  );

  assign wr_stb = wr_req.stb;
  assign sdo_oe = !cs_n && rd_active;
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk
  import sreg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sdo,
  input logic             sdo_oe,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             cmd_rd,
  input logic             armed,
  input logic             wr_stb
);
  // R4
  idle_sdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo);

  // R5
  wr_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (bit_cnt >= CNT_CMD) && !cmd_rd) |-> !sdo_oe);

  // R5
  cmd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt < CNT_CMD) |-> !sdo_oe);

  // R2
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R6
  stb_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(!cs_n) && ($past(bit_cnt) == CNT_FRAME_LAST)));

  // R9
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_FRAME);

  // R7
  unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (bit_cnt == '0));

  // R3
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (bit_cnt == CNT_CMD));
endmodule

bind sreg_port sreg_port_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .sdo     (sdo),
  .sdo_oe  (sdo_oe),
  .bit_cnt (bit_cnt),
  .cmd_rd  (cmd_rd),
  .armed   (armed),
  .wr_stb  (wr_stb)
);

// File: tb/sim_sreg_port.sv
module sim_sreg_port;
  localparam int CLK_PER = 10;
  localparam int NREGS   = 8;
  localparam int WDOG    = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b0;
  logic sdi = 1'b0;
  logic edge_sel = 1'b1;
  logic sdo, sdo_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit oe_seen = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  sreg_port #(.NREGS(NREGS)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sdi(sdi), .edge_sel(edge_sel), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  // behavioural reference model
  int       m_cnt;
  int       m_shifts;
  bit       m_armed, m_prev_sclk, m_act;
  bit [15:0] m_cmd;
  bit [7:0]  m_dat, m_rbyte;
  bit [7:0]  m_regs [NREGS];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_shifts = 0; m_armed = 0; m_prev_sclk = 0; m_act = 0;
      m_cmd = '0; m_dat = '0; m_rbyte = '0;
      for (int i = 0; i < NREGS; i++) m_regs[i] = '0;
    end else begin
      bit rise, fall;
      int a;
      rise = sclk && !m_prev_sclk;
      fall = !sclk && m_prev_sclk;
      if (cs_n) begin
        m_armed = 1; m_cnt = 0; m_cmd = '0; m_dat = '0; m_act = 0; m_shifts = 0;
      end else if (m_armed) begin
        if (m_act && (edge_sel ? (fall && m_cnt > 16) : (rise && m_cnt >= 16 && m_cnt < 24)))
          m_shifts++;
        if (rise && m_cnt < 24) begin
          if (m_cnt < 16) m_cmd[m_cnt] = sdi;
          else            m_dat[m_cnt-16] = sdi;
          if (m_cnt == 15 && m_cmd[0]) begin
            m_act = 1; m_shifts = 0;
            a = int'(m_cmd[6:1]);
            m_rbyte = (a < NREGS) ? m_regs[a] : 8'h00;
          end
          if (m_cnt == 23 && !m_cmd[0] && int'(m_cmd[6:1]) < NREGS)
            m_regs[m_cmd[6:1]] = m_dat;
          m_cnt++;
        end
      end
      m_prev_sclk = sclk;
    end
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    #(CLK_PER/4);
    if (rst_n && !done) begin
      logic exp_oe, exp_sdo;
      exp_oe  = !cs_n && m_act;
      exp_sdo = (m_act && m_shifts < 8) ? m_rbyte[m_shifts] : 1'b0;
      if (sdo_oe) oe_seen = 1;
      n_checks++;
      if (sdo_oe !== exp_oe) begin
        n_fail++;
        $display("FAIL %s sdo_oe actual=%0b expected=%0b t=%0t",
                 cs_n ? "R4" : "R5", sdo_oe, exp_oe, $time);
      end
      n_checks++;
      if (sdo !== exp_sdo) begin
        n_fail++;
        $display("FAIL R3 sdo actual=%0b expected=%0b t=%0t", sdo, exp_sdo, $time);
      end
    end
  end

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] cmd, input logic [7:0] wd, input int nbits,
                      input bit cut, output logic [7:0] rd);
    rd = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi  = (i < 16) ? cmd[i] : ((i < 24) ? wd[i-16] : 1'b1);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
      if (edge_sel && i >= 16 && i < 24) rd[i-16] = sdo;
      sclk = 1'b1;
      if (cut && i == nbits - 1) cs_n = 1'b1;
      repeat (2) @(negedge clk);
      if (!edge_sel && i >= 15 && i < 23) rd[i-15] = sdo;
    end
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [5:0] addr, input logic [7:0] val);
    logic [7:0] dummy;
    xfer({9'h000, addr, 1'b0}, val, 24, 1'b0, dummy);
  endtask

  task automatic rd_reg(input logic [5:0] addr, input logic es, output logic [7:0] v);
    edge_sel = es;
    xfer({9'h000, addr, 1'b1}, 8'h00, 24, 1'b0, v);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check8("R10 sdo_oe after reset", {7'h0, sdo_oe}, 8'h00);
    check8("R10 sdo after reset", {7'h0, sdo}, 8'h00);

    // R7: cs_n never went high since reset, this write must be ignored
    wr_reg(6'd1, 8'hA5);
    rd_reg(6'd1, 1'b1, v);
    check8("R7 no write without select edge", v, 8'h00);

    // R10 all registers cleared
    for (int i = 0; i < NREGS; i++) begin
      rd_reg(6'(i), 1'b1, v);
      check8("R10 register reset value", v, 8'h00);
    end

    // R2 / R3 write then read under both edge settings, R5 oe during write
    oe_seen = 0;
    wr_reg(6'd3, 8'h5A);
    check8("R5 oe stayed low in write", {7'h0, oe_seen}, 8'h00);
    rd_reg(6'd3, 1'b1, v);
    check8("R2 R3 read edge_sel=1", v, 8'h5A);
    rd_reg(6'd3, 1'b0, v);
    check8("R3 read edge_sel=0", v, 8'h5A);
    wr_reg(6'(NREGS-1), 8'hC3);
    rd_reg(6'(NREGS-1), 1'b0, v);
    check8("R2 last register", v, 8'hC3);

    // R4 deselected after read
    check8("R4 sdo_oe deselected", {7'h0, sdo_oe}, 8'h00);
    check8("R4 sdo deselected", {7'h0, sdo}, 8'h00);

    // R1 upper command bits ignored
    xfer(16'hFE0A, 8'h3C, 24, 1'b0, v);
    edge_sel = 1'b1;
    xfer(16'hFF0B, 8'h00, 24, 1'b0, v);
    check8("R1 upper command bits ignored", v, 8'h3C);

    // R6 aborted writes
    xfer(16'h0006, 8'hFF, 20, 1'b0, v);
    rd_reg(6'd3, 1'b1, v);
    check8("R6 early deselect", v, 8'h5A);
    xfer(16'h0006, 8'h11, 24, 1'b1, v);
    rd_reg(6'd3, 1'b0, v);
    check8("R6 deselect with last edge", v, 8'h5A);

    // R8 out-of-range address
    wr_reg(6'd40, 8'h77);
    rd_reg(6'd40, 1'b1, v);
    check8("R8 out-of-range read", v, 8'h00);
    rd_reg(6'd0, 1'b1, v);
    check8("R8 no alias write", v, 8'h00);

    // R9 extra clocks after the frame
    xfer(16'h0004, 8'h81, 30, 1'b0, v);
    rd_reg(6'd2, 1'b0, v);
    check8("R9 extra edges ignored", v, 8'h81);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule